// File: doc/BRIEF.md
# Dual-Half Timer with Match Interrupts

This block is a general-purpose timer that sits behind a single-cycle register bus. It runs in one of two configurations. In the wide configuration, half A becomes a single 32-bit counter that steps on every system clock and ignores its prescaler, and half B is held still. In the split configuration, A and B are independent 16-bit counters. Each split half has its own 8-bit prescaler and runs periodically between zero and its load value.

Each half compares the value its counter is about to take against its own match register. When match interrupts are enabled in that half's mode register, a hit sets a sticky raw flag. The two flags sit in separate byte lanes of shared mask, raw-status, masked-status and write-1-to-clear registers. Each half drives its own interrupt line from its byte of the masked status.

Each half is controlled by a two-state machine. `HS_IDLE` holds the counter and keeps the prescaler at zero. `HS_RUN` advances the prescaler and steps the counter on every prescaler tick. The transition START (`HS_IDLE` to `HS_RUN`) is taken when the half is enabled, its mode field selects periodic operation, and the half may run in the current configuration. The transition STOP (`HS_RUN` to `HS_IDLE`) is taken as soon as any of these conditions drops.

Top module: `dual_half_timer`

## Requirements
- R1: After reset, control reads 0, counter values read 0, raw status reads 0, load A reads 0xFFFFFFFF, load B reads 0x0000FFFF, and both interrupt lines are low.
- R2: Control bit 0 enables half A and bit 8 enables half B, and writing 0 stops counting. A half counts only while its mode bits 3:0 equal 2 (periodic). The first counter step lands on the second clock edge after the enabling write, plus the prescale value.
- R3: With mode bit 4 clear, a split half counts down. From 0 it reloads its 16-bit load value, so one period is load+1 steps.
- R4: In split configuration a half with prescale value P (0 to 255) steps once every P+1 clocks.
- R5: With mode bit 4 set, a half counts up. When the count is at or above the load value, the next step wraps it to 0.
- R6: With config bit 0 clear (wide), half A is a 32-bit counter that steps on every clock and ignores its prescaler, and half B never steps. Config bit 0 set selects split.
- R7: A raw flag (bit 4 for half A, bit 11 for half B) is set on the same edge on which a counter step makes the counter equal its match register, and only if mode bit 5 is set. The flag stays set until it is cleared.
- R8: Masked status equals raw AND mask. irq_a is the OR of masked bits 7:0, and irq_b is the OR of masked bits 15:8.
- R9: Writing 1 to a bit of the clear register clears that raw flag on the write edge. If a set and a clear reach the same flag in the same cycle, the flag stays set.
- R10: The counter value registers are read-only. Writing a load register while that half's control bit is 0 also loads its counter, cut to 16 bits in split configuration.
- R11: The registers sit at these byte offsets: control 0x00, config 0x04, mode A/B 0x08/0x0C, load A/B 0x10/0x14, match A/B 0x18/0x1C, prescale A/B 0x20/0x24, mask 0x28, raw 0x2C, masked 0x30, clear 0x34, value A/B 0x38/0x3C. Reads are combinational in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe; a write happens on an edge when both select and strobe are high |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_a | output | 1 | Half A interrupt line |
| irq_b | output | 1 | Half B interrupt line |

## Verification
A register write takes effect on the edge it is presented at. So config, mask and clear changes, along with a counter load on a stopped half, are visible at the next falling edge. A START needs one more edge, and the first step lands P edges later. The expected counter value at every falling edge is computed as a step count n = (k-2-P)/(P+1)+1, where k counts edges since the enabling write. A match flag, and the interrupt line it drives, is expected on the very edge the counter reaches the match value, so the bench samples both together at the falling edge after it. The set-versus-clear case lines up a clear write with the edge that sets the flag again, one full period after the first hit.

// File: rtl/dht_pkg.sv
package dht_pkg;
    localparam int DW = 32;
    localparam int AW = 6;
    localparam int HW = 16;
    localparam int PW = 8;
    localparam int NH = 2;
    localparam int SW = 16;

    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_CFG    = 'h04;
    localparam int OFF_MODE0  = 'h08;
    localparam int OFF_LOAD0  = 'h10;
    localparam int OFF_MATCH0 = 'h18;
    localparam int OFF_PRE0   = 'h20;
    localparam int OFF_MASK   = 'h28;
    localparam int OFF_RAW    = 'h2C;
    localparam int OFF_MSTAT  = 'h30;
    localparam int OFF_CLEAR  = 'h34;
    localparam int OFF_VAL0   = 'h38;

    localparam int MW = 6;
    localparam int MD_UP  = 4;
    localparam int MD_MIE = 5;
    localparam logic [3:0] MD_PERIODIC = 4'h2;

    typedef enum logic {HS_IDLE, HS_RUN} half_st_t;

    function automatic int match_bit(input int h);
        return (h == 0) ? 4 : 11;
    endfunction
endpackage

// File: rtl/dht_regs.sv
module dht_regs
    import dht_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_we,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    output logic [NH-1:0]          en,
    output logic                   split,
    output logic [NH-1:0][MW-1:0]  mode,
    output logic [NH-1:0][DW-1:0]  load,
    output logic [NH-1:0][DW-1:0]  match,
    output logic [NH-1:0][PW-1:0]  pre,
    output logic [SW-1:0]          mask,
    output logic [NH-1:0]          load_wr,
    output logic                   clr_wr,
    input  logic [SW-1:0]          raw,
    input  logic [SW-1:0]          mstat,
    input  logic [NH-1:0][DW-1:0]  value
);
    localparam logic [DW-1:0] HALF_ONES = {{(DW-HW){1'b0}}, {HW{1'b1}}};

    logic wr;
    int   ai;

    assign wr = bus_sel && bus_we;
    assign ai = int'(bus_addr);

    function automatic logic [DW-1:0] keep(input int h, input logic [DW-1:0] x);
        return (h == 0) ? x : {{(DW-HW){1'b0}}, x[HW-1:0]};
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= '0;
            split <= 1'b0;
            mask  <= '0;
            for (int h = 0; h < NH; h++) begin
                mode[h]  <= '0;
                load[h]  <= (h == 0) ? '1 : HALF_ONES;
                match[h] <= '0;
                pre[h]   <= '0;
            end
        end else if (wr) begin
            if (ai == OFF_CTRL) begin
                for (int h = 0; h < NH; h++) en[h] <= bus_wdata[h*8];
            end
            if (ai == OFF_CFG)  split <= bus_wdata[0];
            if (ai == OFF_MASK) mask  <= bus_wdata[SW-1:0];
            for (int h = 0; h < NH; h++) begin
                if (ai == OFF_MODE0 + 4*h)  mode[h]  <= bus_wdata[MW-1:0];
                if (ai == OFF_LOAD0 + 4*h)  load[h]  <= keep(h, bus_wdata);
                if (ai == OFF_MATCH0 + 4*h) match[h] <= keep(h, bus_wdata);
                if (ai == OFF_PRE0 + 4*h)   pre[h]   <= bus_wdata[PW-1:0];
            end
        end
    end

    always_comb begin
        clr_wr = wr && (ai == OFF_CLEAR);
        for (int h = 0; h < NH; h++) load_wr[h] = wr && (ai == OFF_LOAD0 + 4*h);
    end

    always_comb begin
        bus_rdata = '0;
        case (ai)
            OFF_CTRL:  for (int h = 0; h < NH; h++) bus_rdata[h*8] = en[h];
            OFF_CFG:   bus_rdata = {{(DW-1){1'b0}}, split};
            OFF_MASK:  bus_rdata = {{(DW-SW){1'b0}}, mask};
            OFF_RAW:   bus_rdata = {{(DW-SW){1'b0}}, raw};
            OFF_MSTAT: bus_rdata = {{(DW-SW){1'b0}}, mstat};
            default:   bus_rdata = '0;
        endcase
        for (int h = 0; h < NH; h++) begin
            if (ai == OFF_MODE0 + 4*h)  bus_rdata = {{(DW-MW){1'b0}}, mode[h]};
            if (ai == OFF_LOAD0 + 4*h)  bus_rdata = load[h];
            if (ai == OFF_MATCH0 + 4*h) bus_rdata = match[h];
            if (ai == OFF_PRE0 + 4*h)   bus_rdata = {{(DW-PW){1'b0}}, pre[h]};
            if (ai == OFF_VAL0 + 4*h)   bus_rdata = value[h];
        end
    end
endmodule

// File: rtl/dht_half.sv
module dht_half
    import dht_pkg::*;
#(
    parameter bit WIDE_OK = 1'b1
)
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          split,
    input  logic [MW-1:0] mode,
    input  logic [DW-1:0] load,
    input  logic [DW-1:0] match,
    input  logic [PW-1:0] pre,
    input  logic          load_wr,
    input  logic [DW-1:0] load_data,
    output logic [DW-1:0] value,
    output logic          hit
);
    half_st_t      state_q, state_d;
    logic [DW-1:0] cnt_q, cur, lim, nxt;
    logic [PW-1:0] pre_q, pre_d;
    logic          wide, go, tick;

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] x, input logic w);
        return w ? x : {{(DW-HW){1'b0}}, x[HW-1:0]};
    endfunction

    assign wide = WIDE_OK && !split;
    assign go   = en && (mode[3:0] == MD_PERIODIC) && (split || WIDE_OK);

    // Transitions: START (idle->run on go), STOP (run->idle when go drops)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (go)  state_d = HS_RUN;
            HS_RUN:  if (!go) state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cur   = fit(cnt_q, wide);
        lim   = fit(load, wide);
        tick  = 1'b0;
        pre_d = pre_q;
        nxt   = cur;
        unique case (state_q)
            HS_IDLE: pre_d = '0;
            HS_RUN: begin
                if (wide || (pre_q >= pre)) begin
                    tick  = 1'b1;
                    pre_d = '0;
                end else begin
                    pre_d = pre_q + PW'(1);
                end
                if (mode[MD_UP]) nxt = (cur >= lim) ? '0 : cur + DW'(1);
                else             nxt = (cur == '0)  ? lim : cur - DW'(1);
            end
        endcase
        hit = tick && mode[MD_MIE] && (nxt == fit(match, wide));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
            if (load_wr && !en) cnt_q <= fit(load_data, wide);
            else if (tick)      cnt_q <= nxt;
        end
    end

    assign value = fit(cnt_q, wide);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_IDLE && !load_wr) |=> $stable(cnt_q)); // R2
    AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (state_q == HS_IDLE)); // R2
endmodule

// File: rtl/dht_irq.sv
module dht_irq
    import dht_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NH-1:0] set,
    input  logic          clr_wr,
    input  logic [SW-1:0] clr_data,
    input  logic [SW-1:0] mask,
    output logic [SW-1:0] raw,
    output logic [SW-1:0] mstat,
    output logic [NH-1:0] irq
);
    logic [NH-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            for (int h = 0; h < NH; h++) begin
                if (set[h])                                flag_q[h] <= 1'b1;
                else if (clr_wr && clr_data[match_bit(h)]) flag_q[h] <= 1'b0;
            end
        end
    end

    always_comb begin
        raw = '0;
        for (int h = 0; h < NH; h++) raw[match_bit(h)] = flag_q[h];
        mstat = raw & mask;
    end

    for (genvar g = 0; g < NH; g++) begin : g_lane
        localparam int MB = match_bit(g);
        assign irq[g] = |mstat[g*8 +: 8];

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> raw[MB]); // R9
        AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_data[MB] && !set[g]) |=> !raw[MB]); // R9
    end
endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
    import dht_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_a,
    output logic          irq_b
);
    logic [NH-1:0]          en, load_wr, hit, irq;
    logic                   split, clr_wr;
    logic [NH-1:0][MW-1:0]  mode;
    logic [NH-1:0][DW-1:0]  load, match, value;
    logic [NH-1:0][PW-1:0]  pre;
    logic [SW-1:0]          mask, raw, mstat;

    dht_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .en(en), .split(split), .mode(mode), .load(load), .match(match),
        .pre(pre), .mask(mask), .load_wr(load_wr), .clr_wr(clr_wr),
        .raw(raw), .mstat(mstat), .value(value)
    );

    for (genvar g = 0; g < NH; g++) begin : g_half
        dht_half #(.WIDE_OK(g == 0)) u_half (
            .clk(clk), .rst_n(rst_n), .en(en[g]), .split(split),
            .mode(mode[g]), .load(load[g]), .match(match[g]), .pre(pre[g]),
            .load_wr(load_wr[g]), .load_data(bus_wdata),
            .value(value[g]), .hit(hit[g])
        );
    end

    dht_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set(hit), .clr_wr(clr_wr),
        .clr_data(bus_wdata[SW-1:0]), .mask(mask),
        .raw(raw), .mstat(mstat), .irq(irq)
    );

    assign irq_a = irq[0];
    assign irq_b = irq[1];

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> (mask[4] && raw[4])); // R8
endmodule

// File: tb/tb_dual_half_timer.sv
`timescale 1ns/1ps
module tb_dual_half_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_a, irq_b;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    dual_half_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input int a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 6'(a);
        #0.2;
        d = bus_rdata;
    endtask

    function automatic int steps(input int k, input int p);
        return (k >= 2 + p) ? ((k - 2 - p) / (p + 1) + 1) : 0;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, vb;
        int n, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R11 offsets
        rd('h00, v); chk("R1", "ctrl", v, 32'h0);
        rd('h10, v); chk("R1", "load A", v, 32'hFFFF_FFFF);
        rd('h14, v); chk("R1", "load B", v, 32'h0000_FFFF);
        rd('h38, v); chk("R1", "value A", v, 32'h0);
        rd('h2C, v); chk("R1", "raw", v, 32'h0);
        chk("R1", "irq lines", {30'b0, irq_b, irq_a}, 32'h0);

        // R3/R4/R2: split down-count, prescaler sweep on half A
        wr('h04, 32'h1);
        wr('h08, 32'h02);
        for (int p = 0; p < 8; p++) begin
            wr('h00, 32'h0);
            wr('h20, p);
            wr('h10, 32'd5);
            rd('h38, v); chk("R10", "load into stopped A", v, 32'd5);
            wr('h00, 32'h1);
            for (int k = 0; k <= 40; k++) begin
                n = steps(k, p);
                e = 5 - (n % 6);
                rd('h38, v); chk("R4", $sformatf("A down p=%0d k=%0d", p, k), v, e);
                @(negedge clk);
            end
        end
        wr('h00, 32'h0);
        rd('h2C, v); chk("R7", "no flag with match enable off", v, 32'h0);

        // R7/R8/R9: match on half A, set beats clear
        wr('h20, 32'h0);
        wr('h10, 32'd5);
        wr('h18, 32'd3);
        wr('h08, 32'h22);
        wr('h28, 32'h10);
        wr('h34, 32'hFFFF);
        wr('h00, 32'h1);
        @(negedge clk); @(negedge clk);
        rd('h2C, v); chk("R7", "raw before match", v, 32'h0);
        @(negedge clk);
        rd('h38, v); chk("R3", "A at match", v, 32'd3);
        rd('h2C, v); chk("R7", "raw A flag", v, 32'h10);
        rd('h30, v); chk("R8", "masked A", v, 32'h10);
        chk("R8", "irq_a high", {31'b0, irq_a}, 32'h1);
        @(negedge clk); @(negedge clk);
        wr('h34, 32'h10);
        rd('h2C, v); chk("R9", "raw cleared", v, 32'h0);
        chk("R9", "irq_a low after clear", {31'b0, irq_a}, 32'h0);
        @(negedge clk); @(negedge clk);
        wr('h34, 32'h10);
        rd('h2C, v); chk("R9", "set wins over clear", v, 32'h10);
        wr('h00, 32'h0);
        wr('h28, 32'h0);
        rd('h30, v); chk("R8", "masked with mask 0", v, 32'h0);
        chk("R8", "irq_a masked", {31'b0, irq_a}, 32'h0);
        wr('h28, 32'h800);
        chk("R8", "wrong lane mask", {30'b0, irq_b, irq_a}, 32'h0);
        wr('h28, 32'h10);
        chk("R8", "irq_a unmasked", {31'b0, irq_a}, 32'h1);

        // R5/R7: half B up-count with prescale 1 and match 2
        wr('h34, 32'hFFFF);
        wr('h28, 32'h800);
        wr('h0C, 32'h32);
        wr('h24, 32'h1);
        wr('h14, 32'd4);
        wr('h1C, 32'd2);
        wr('h00, 32'h100);
        for (int k = 0; k <= 30; k++) begin
            n = steps(k, 1);
            e = (n == 0) ? 4 : ((n - 1) % 5);
            rd('h3C, v); chk("R5", $sformatf("B up k=%0d", k), v, e);
            chk("R7", $sformatf("irq_b k=%0d", k), {31'b0, irq_b}, (n >= 3) ? 32'h1 : 32'h0);
            @(negedge clk);
        end
        rd('h2C, v); chk("R7", "raw B flag bit 11", v, 32'h800);
        wr('h00, 32'h0);

        // R6: wide configuration, crosses the 16-bit boundary, B held
        wr('h04, 32'h0);
        wr('h08, 32'h02);
        wr('h20, 32'h3);
        wr('h10, 32'h0001_0001);
        rd('h38, v); chk("R6", "wide load", v, 32'h0001_0001);
        wr('h0C, 32'h02);
        rd('h3C, vb);
        wr('h00, 32'h101);
        for (int k = 0; k <= 10; k++) begin
            n = (k >= 2) ? k - 1 : 0;
            rd('h38, v); chk("R6", $sformatf("wide A k=%0d", k), v, 32'h0001_0001 - n);
            rd('h3C, v); chk("R6", $sformatf("B held k=%0d", k), v, vb);
            @(negedge clk);
        end
        wr('h00, 32'h0);

        // R2 mode field gating, R10 value read-only
        wr('h04, 32'h1);
        wr('h08, 32'h00);
        wr('h10, 32'd7);
        wr('h00, 32'h1);
        repeat (6) @(negedge clk);
        rd('h38, v); chk("R2", "non-periodic mode holds", v, 32'd7);
        wr('h38, 32'h1234);
        rd('h38, v); chk("R10", "value write ignored", v, 32'd7);
        rd('h00, v); chk("R2", "ctrl readback", v, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule